// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line into characters for a bus-attached peripheral. It samples the incoming line at sixteen times the bit rate, where the bit rate comes from a 12-bit divisor. It finds a start bit and checks that the start bit is real. It then collects five to nine data bits, least significant first, checks an optional parity bit and tests the stop bit. The finished character goes into a receive holding register.

Status for the held character is kept beside it: a receive-complete flag, a framing-error flag, a parity-error flag and an overrun flag. When a nine-bit character is received, its top bit appears on a separate output. A receiver enable turns reception on and off. An interrupt enable decides whether a held character raises the interrupt line.

The data location is shared with a transmitter. A bus read returns the held character and marks it consumed. A bus write is passed straight through to the transmit side and leaves the receiver alone.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, rx_full, frame_err, overrun_err, parity_err and irq are all 0.
- R2: One bit lasts 16 × (divisor + 1) clocks. Each bit value is the majority of the line samples at sub-bit ticks 7, 8 and 9 of that bit.
- R3: A falling edge whose start-bit majority vote reads high sends the receiver back to idle, and no character is stored.
- R4: size_code selects the character length: 000 gives 5 bits, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. The codes 100 to 110 give 8 bits. Data arrives least significant bit first, and rx_byte bits above the character length read 0.
- R5: For a 9-bit character, the ninth data bit (bit 8) is presented on rx_bit8. For shorter characters, rx_bit8 is 0.
- R6: parity_mode selects the parity: 00 or 01 means no parity bit, 10 means even, 11 means odd. parity_err is set for the held character when the received parity bit differs from the one computed over its data bits.
- R7: frame_err is set for the held character when its stop bit votes low.
- R8: rx_full goes high once a character completes. A bus_rd pulse clears rx_full and overrun_err.
- R9: If a character completes while rx_full is high and no read happens in the same cycle, overrun_err is set. The new character is then discarded, and rx_byte, rx_bit8, frame_err and parity_err keep describing the held character.
- R10: While rx_enable is low, the receiver stays idle and no character is stored.
- R11: irq equals rx_full AND done_irq_en.
- R12: bus_wr and bus_wdata appear on tx_load and tx_byte in the same cycle, and a write changes neither rx_byte nor rx_full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable |
| done_irq_en | input | 1 | Receive-complete interrupt enable |
| divisor | input | 12 | Bit-rate divisor; bit = 16 × (divisor + 1) clocks |
| size_code | input | 3 | Character length code |
| parity_mode | input | 2 | Parity selection code |
| rx_in | input | 1 | Serial input line, idle high |
| bus_rd | input | 1 | Read strobe of the shared data location |
| bus_wr | input | 1 | Write strobe of the shared data location |
| bus_wdata | input | 8 | Write data for the transmitter |
| tx_load | output | 1 | Write strobe forwarded to the transmitter |
| tx_byte | output | 8 | Write data forwarded to the transmitter |
| rx_byte | output | 8 | Held character, bits 7..0 |
| rx_bit8 | output | 1 | Ninth data bit of the held character |
| rx_full | output | 1 | Unread character present |
| frame_err | output | 1 | Held character had a low stop bit |
| overrun_err | output | 1 | A character was lost because the register was full |
| parity_err | output | 1 | Held character failed the parity check |
| irq | output | 1 | Receive-complete interrupt |

## Verification
The bench targets several corner cases. A short low glitch must not start reception; a receiver that skips start validation would store a phantom character. After a frame whose stop bit is low, the line stays low for a while and triggers a false restart; a design without start validation would report a spurious second character or an overrun. A second character that arrives before the first is read must leave the first in place with overrun set; a design that overwrites the register would show the newer data. The bench also covers every length code, including a reserved one, with the parity bit mismatched on purpose. A wrong length decode or inverted odd/even sense would show up there as shifted data, a stray rx_bit8 or a wrong parity_err.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int unsigned CHAR_MAX_BITS = 9;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_MAX_BITS-1:0] data;
    logic                     frame_bad;
    logic                     parity_bad;
  } rx_char_t;

  // character length from the shared 3-bit code; reserved codes fall back to 8
  function automatic logic [3:0] char_bits(input logic [2:0] code);
    logic [3:0] n;
    case (code)
      3'b000:  n = 4'd5;
      3'b001:  n = 4'd6;
      3'b010:  n = 4'd7;
      3'b111:  n = 4'd9;
      default: n = 4'd8;
    endcase
    return n;
  endfunction

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  // the line idles high, so reset to ones to avoid a false start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == divisor);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run & wrap;

  // R2: with a nonzero divisor held steady, ticks are never back to back
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor != '0 && $stable(divisor)) |=> !tick);

endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       line,
  input  logic       tick,
  input  logic [2:0] size_code,
  input  logic [1:0] parity_mode,
  output logic       run,
  output logic       done,
  output rx_char_t   char_out
);

  localparam int unsigned SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] S_A   = SUB_W'(OVS/2 - 1);
  localparam logic [SUB_W-1:0] S_B   = SUB_W'(OVS/2);
  localparam logic [SUB_W-1:0] S_C   = SUB_W'(OVS/2 + 1);
  localparam logic [SUB_W-1:0] S_END = SUB_W'(OVS - 1);

  rx_state_e              st_q, st_d;
  logic [SUB_W-1:0]       sub_q, sub_d;
  logic [3:0]             idx_q, idx_d;
  logic [CHAR_MAX_BITS-1:0] sh_q, sh_d;
  logic                   sa_q, sa_d, sb_q, sb_d;
  logic                   pacc_q, pacc_d;
  logic                   pbad_q, pbad_d;
  logic                   fbad_q, fbad_d;
  logic                   done_q, done_d;
  logic [3:0]             nbits;
  logic                   vote;
  logic                   odd_sel;

  assign nbits   = char_bits(size_code);
  assign vote    = vote3(sa_q, sb_q, line);
  assign odd_sel = parity_mode[0];

  always_comb begin
    st_d   = st_q;
    sub_d  = sub_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    sa_d   = sa_q;
    sb_d   = sb_q;
    pacc_d = pacc_q;
    pbad_d = pbad_q;
    fbad_d = fbad_q;
    done_d = 1'b0;
    if (!en) begin
      st_d = RX_IDLE;
    end else if (st_q == RX_IDLE) begin
      if (!line) begin
        st_d  = RX_START;
        sub_d = '0;
      end
    end else if (tick) begin
      sub_d = (sub_q == S_END) ? '0 : sub_q + 1'b1;
      if (sub_q == S_A) sa_d = line;
      if (sub_q == S_B) sb_d = line;
      if (sub_q == S_C) begin
        case (st_q)
          RX_START: if (vote) st_d = RX_IDLE;
          RX_DATA: begin
            sh_d[idx_q] = vote;
            pacc_d      = pacc_q ^ vote;
          end
          RX_PAR:   pbad_d = (vote != (pacc_q ^ odd_sel));
          RX_STOP: begin
            fbad_d = ~vote;
            done_d = 1'b1;
            st_d   = RX_IDLE;
          end
          default: ;
        endcase
      end
      if (sub_q == S_END) begin
        case (st_q)
          RX_START: begin
            st_d   = RX_DATA;
            idx_d  = '0;
            sh_d   = '0;
            pacc_d = 1'b0;
            pbad_d = 1'b0;
          end
          RX_DATA: begin
            if (idx_q == nbits - 4'd1) st_d = parity_mode[1] ? RX_PAR : RX_STOP;
            else                       idx_d = idx_q + 4'd1;
          end
          RX_PAR:  st_d = RX_STOP;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      sub_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      sa_q   <= 1'b1;
      sb_q   <= 1'b1;
      pacc_q <= 1'b0;
      pbad_q <= 1'b0;
      fbad_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sub_q  <= sub_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      sa_q   <= sa_d;
      sb_q   <= sb_d;
      pacc_q <= pacc_d;
      pbad_q <= pbad_d;
      fbad_q <= fbad_d;
      done_q <= done_d;
    end
  end

  assign run                 = (st_q != RX_IDLE);
  assign done                = done_q;
  assign char_out.data       = sh_q;
  assign char_out.frame_bad  = fbad_q;
  assign char_out.parity_bad = pbad_q;

  // R10: a disabled receiver is idle on the next cycle
  assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st_q == RX_IDLE));

  // R8: a completed character is reported for exactly one cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: the data index never runs past the selected length
  assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_DATA && $stable(size_code)) |-> (idx_q < nbits));

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import serial_rx_pkg::*;
#(
  parameter int unsigned DIV_W       = 12,
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_enable,
  input  logic             done_irq_en,
  input  logic [DIV_W-1:0] divisor,
  input  logic [2:0]       size_code,
  input  logic [1:0]       parity_mode,
  input  logic             rx_in,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic             tx_load,
  output logic [7:0]       tx_byte,
  output logic [7:0]       rx_byte,
  output logic             rx_bit8,
  output logic             rx_full,
  output logic             frame_err,
  output logic             overrun_err,
  output logic             parity_err,
  output logic             irq
);

  logic     line_s;
  logic     run;
  logic     tick;
  logic     done;
  rx_char_t new_char;

  rx_char_t hold_q, hold_d;
  logic     full_q, full_d;
  logic     ovr_q, ovr_d;
  logic     accept;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_in),
    .q     (line_s)
  );

  srx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .divisor (divisor),
    .tick    (tick)
  );

  srx_framer #(.OVS(OVS)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (rx_enable),
    .line        (line_s),
    .tick        (tick),
    .size_code   (size_code),
    .parity_mode (parity_mode),
    .run         (run),
    .done        (done),
    .char_out    (new_char)
  );

  // a read in the same cycle frees the register for the arriving character
  assign accept = done & (~full_q | bus_rd);

  always_comb begin
    hold_d = hold_q;
    full_d = full_q;
    ovr_d  = ovr_q;
    if (accept) begin
      hold_d = new_char;
      full_d = 1'b1;
      ovr_d  = 1'b0;
    end else if (done) begin
      ovr_d  = 1'b1;
    end else if (bus_rd) begin
      full_d = 1'b0;
      ovr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  assign tx_load     = bus_wr;
  assign tx_byte     = bus_wdata;
  assign rx_byte     = hold_q.data[7:0];
  assign rx_bit8     = hold_q.data[8];
  assign rx_full     = full_q;
  assign frame_err   = hold_q.frame_bad;
  assign parity_err  = hold_q.parity_bad;
  assign overrun_err = ovr_q;
  assign irq         = full_q & done_irq_en;

  // R9: a character arriving into a full, unread register is dropped
  assert_overrun_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full_q && !bus_rd) |=> (overrun_err && $stable(rx_byte) && $stable(rx_bit8)));

  // R8: a read with no arrival empties the register
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !done) |=> (!rx_full && !overrun_err));

  // R12: a write to the shared location leaves the receive side untouched
  assert_write_inert_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && !done) |=> ($stable(rx_byte) && $stable(rx_full)));

endmodule

// File: tb/serial_rx_unit_tb.sv
module serial_rx_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 9;

  // {size_code[15:13], parity_mode[12:11], data[10:2], bad_parity[1], bad_stop[0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {3'b011, 2'b00, 9'h0A5, 1'b0, 1'b0},
    {3'b000, 2'b10, 9'h1FF, 1'b0, 1'b0},
    {3'b001, 2'b11, 9'h02A, 1'b0, 1'b0},
    {3'b010, 2'b10, 9'h055, 1'b1, 1'b0},
    {3'b111, 2'b00, 9'h1C3, 1'b0, 1'b0},
    {3'b111, 2'b11, 9'h0F0, 1'b1, 1'b0},
    {3'b011, 2'b00, 9'h03C, 1'b0, 1'b1},
    {3'b100, 2'b01, 9'h081, 1'b1, 1'b0},
    {3'b011, 2'b11, 9'h000, 1'b0, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        rx_enable;
  logic        done_irq_en;
  logic [11:0] divisor;
  logic [2:0]  size_code;
  logic [1:0]  parity_mode;
  logic        rx_in;
  logic        bus_rd;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic        tx_load;
  logic [7:0]  tx_byte;
  logic [7:0]  rx_byte;
  logic        rx_bit8;
  logic        rx_full;
  logic        frame_err;
  logic        overrun_err;
  logic        parity_err;
  logic        irq;

  int total;
  int bad;
  bit finished;

  serial_rx_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_enable   (rx_enable),
    .done_irq_en (done_irq_en),
    .divisor     (divisor),
    .size_code   (size_code),
    .parity_mode (parity_mode),
    .rx_in       (rx_in),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .tx_load     (tx_load),
    .tx_byte     (tx_byte),
    .rx_byte     (rx_byte),
    .rx_bit8     (rx_bit8),
    .rx_full     (rx_full),
    .frame_err   (frame_err),
    .overrun_err (overrun_err),
    .parity_err  (parity_err),
    .irq         (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int len_of(input logic [2:0] code);
    case (code)
      3'b000:  return 5;
      3'b001:  return 6;
      3'b010:  return 7;
      3'b111:  return 9;
      default: return 8;
    endcase
  endfunction

  function automatic logic [8:0] clip(input logic [8:0] d, input int n);
    logic [9:0] m;
    m = (10'd1 << n) - 10'd1;
    return d & m[8:0];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic line_for(input logic v, input int clocks);
    rx_in = v;
    repeat (clocks) @(negedge clk);
  endtask

  // sends start, data LSB first, optional parity, stop, then two idle bits
  task automatic send_frame(input logic [2:0] code, input logic [1:0] pm,
                            input logic [8:0] d, input logic bp, input logic bs);
    int bt;
    int n;
    logic [8:0] m;
    logic pb;
    bt = 16 * (int'(divisor) + 1);
    n  = len_of(code);
    m  = clip(d, n);
    pb = (^m) ^ (pm == 2'b11) ^ bp;
    size_code   = code;
    parity_mode = pm;
    @(negedge clk);
    line_for(1'b0, bt);
    for (int k = 0; k < n; k++) line_for(m[k], bt);
    if (pm[1]) line_for(pb, bt);
    line_for(~bs, bt);
    line_for(1'b1, 2 * bt);
  endtask

  task automatic read_pulse();
    @(negedge clk);
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total       = 0;
    bad         = 0;
    finished    = 1'b0;
    rst_n       = 1'b0;
    rx_enable   = 1'b1;
    done_irq_en = 1'b1;
    divisor     = 12'd1;
    size_code   = 3'b011;
    parity_mode = 2'b00;
    rx_in       = 1'b1;
    bus_rd      = 1'b0;
    bus_wr      = 1'b0;
    bus_wdata   = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 full",    16'(rx_full),     16'h0);
    chk("R1 ferr",    16'(frame_err),   16'h0);
    chk("R1 ovr",     16'(overrun_err), 16'h0);
    chk("R1 perr",    16'(parity_err),  16'h0);
    chk("R1 irq",     16'(irq),         16'h0);

    // table walk: R2 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < NVEC; i++) begin
      logic [8:0] m;
      int n;
      n = len_of(VEC[i][15:13]);
      m = clip(VEC[i][10:2], n);
      send_frame(VEC[i][15:13], VEC[i][12:11], VEC[i][10:2], VEC[i][1], VEC[i][0]);
      chk("R8 full set",  16'(rx_full),     16'h1);
      chk("R4 data",      16'(rx_byte),     16'(m[7:0]));
      chk("R5 bit8",      16'(rx_bit8),     16'(m[8]));
      chk("R7 ferr",      16'(frame_err),   16'(VEC[i][0]));
      chk("R6 perr",      16'(parity_err),  16'(VEC[i][12] & VEC[i][1]));
      chk("R9 no ovr",    16'(overrun_err), 16'h0);
      chk("R11 irq",      16'(irq),         16'h1);
      read_pulse();
      chk("R8 read clr",  16'(rx_full),     16'h0);
    end

    // R3 short glitch on the line
    @(negedge clk);
    line_for(1'b0, 6);
    line_for(1'b1, 64);
    chk("R3 glitch", 16'(rx_full), 16'h0);

    // R10 disabled receiver
    rx_enable = 1'b0;
    send_frame(3'b011, 2'b00, 9'h05A, 1'b0, 1'b0);
    chk("R10 disabled", 16'(rx_full), 16'h0);
    rx_enable = 1'b1;
    repeat (4) @(negedge clk);

    // R9 overrun keeps the first character
    send_frame(3'b011, 2'b00, 9'h011, 1'b0, 1'b0);
    send_frame(3'b011, 2'b00, 9'h022, 1'b0, 1'b1);
    chk("R9 full",  16'(rx_full),     16'h1);
    chk("R9 ovr",   16'(overrun_err), 16'h1);
    chk("R9 data",  16'(rx_byte),     16'h11);
    chk("R9 ferr",  16'(frame_err),   16'h0);

    // R12 write is forwarded and does not disturb the held character
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_wdata = 8'h77;
    #1;
    chk("R12 tx_load", 16'(tx_load), 16'h1);
    chk("R12 tx_byte", 16'(tx_byte), 16'h77);
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R12 data kept", 16'(rx_byte), 16'h11);
    chk("R12 full kept", 16'(rx_full), 16'h1);

    // R11 interrupt masked
    done_irq_en = 1'b0;
    @(negedge clk);
    chk("R11 masked", 16'(irq), 16'h0);
    done_irq_en = 1'b1;

    read_pulse();
    chk("R8 ovr clr",  16'(overrun_err), 16'h0);
    chk("R8 full clr", 16'(rx_full),     16'h0);

    // R2 slower bit rate
    divisor = 12'd3;
    send_frame(3'b011, 2'b10, 9'h0C6, 1'b0, 1'b0);
    chk("R2 div3 data", 16'(rx_byte),    16'h0C6);
    chk("R2 div3 perr", 16'(parity_err), 16'h0);
    read_pulse();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule